// File: doc/BRIEF.md
# Match-Driven Pulse Generator

This block produces a stable, repeating pulse on a single output pin. A free-running 16-bit timer is compared with a 16-bit compare register, and every pin edge comes from that match in hardware. A host never has to react in time for the waveform to stay exact. In the default accumulate mode the block reloads itself after each match. After a rising edge it adds the pulse width to the compare value. After a falling edge it adds the remainder of the period. It also flips its next-level bit. The timer is never cleared, so each edge lands a fixed number of ticks after the one before it.

A second mode, special-event, returns the timer to zero on a match and leaves the pin alone. The result is a plain periodic tick of compare+1 cycles. Every match in either mode raises a sticky flag for the host to acknowledge whenever it likes. Acknowledge delay never moves an edge.

The host programs the block through a small write port. Address 0 is control: bit0 is run, bit1 is special-event mode and bit2 is the next pin level. Address 1 is the low byte of the compare value and address 2 is its high byte, both taken from data bits 7:0. Address 3 is the pulse width, address 4 loads the timer, and address 5 acknowledges the flag (the data is ignored).

Top module: `match_pulse_gen`

## Requirements
- R1: After reset the pin is low, the flag is clear, the timer is stopped at zero and the pulse width is 1500 ticks.
- R2: While run (control bit0) is set, the timer advances by one each clock and wraps from 65535 to 0. While run is clear, it holds. A write to address 4 loads it.
- R3: In accumulate mode (control bit1 = 0), a cycle with run set and timer equal to compare drives the pin to the next-level bit (control bit2) on the following clock edge. Without a match, the pin does not change. The compare low byte is written at address 1 and the high byte at address 2.
- R4: In accumulate mode, a match that drives the pin high adds the active width to compare and sets the next level to 0. A match that drives it low adds (PERIOD − active width) and sets the next level to 1. High time therefore equals the width, and rise-to-rise equals PERIOD (20000) exactly, across timer wrap and for any acknowledge delay.
- R5: Every match sets the flag. The flag stays set until a write to address 5, and a match in the same cycle as that write wins.
- R6: In special-event mode (control bit1 = 1), a match clears the timer to zero and sets the flag. It leaves the pin, the compare value and the next level unchanged, so matches repeat every compare+1 cycles.
- R7: A width written to address 3 is clamped to the range 600 to 2400.
- R8: A new width first applies at the next match that drives the pin high. The pulse in progress and its matching low time keep the old width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pin_o | output | 1 | Generated pulse output |
| flag_o | output | 1 | Sticky match flag |

## Verification
The assertions assume the host never writes the compare value, the control register or the timer during a match cycle. They also assume the width and period keep each delta well above the few cycles between a match and the next compare. The stimulus follows these rules. It changes the width only about a hundred cycles after a rising edge, long after that edge's match. It reprograms compare, timer and mode only while run is clear. Flag acknowledges are issued from a separate process after a random delay of 1 to 40 cycles. A shared bus lock keeps those writes from colliding with configuration writes. Edge spacing is then checked against the programmed widths, including the runs where the compare value passes the timer's wrap point.

// File: rtl/mpg_pkg.sv
package mpg_pkg;

    localparam int ADDR_W   = 3;
    localparam int NUM_REGS = 6;

    // Register addresses of the host write port
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CMP_LO = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_CMP_HI = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_WIDTH  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_TIMER  = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_ACK    = 3'd5;

    // Control register bit positions
    localparam int CTRL_RUN   = 0;
    localparam int CTRL_SPEC  = 1;
    localparam int CTRL_LEVEL = 2;

    typedef struct packed {
        logic run;
        logic special;
    } ctrl_t;

    typedef struct packed {
        logic pin;
        logic flag;
    } out_t;

endpackage

// File: rtl/mpg_ctrl.sv
module mpg_ctrl
    import mpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [1:0]        ctrl_bits,
    output logic              run,
    output logic              special,
    output logic              ctrl_we,
    output logic              cmp_lo_we,
    output logic              cmp_hi_we,
    output logic              width_we,
    output logic              timer_we,
    output logic              ack_we
);

    logic [NUM_REGS-1:0] strobe;

    // One write strobe per register address
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_strobe
        assign strobe[i] = wr_en && (wr_addr == ADDR_W'(i));
    end

    assign ctrl_we   = strobe[ADDR_CTRL];
    assign cmp_lo_we = strobe[ADDR_CMP_LO];
    assign cmp_hi_we = strobe[ADDR_CMP_HI];
    assign width_we  = strobe[ADDR_WIDTH];
    assign timer_we  = strobe[ADDR_TIMER];
    assign ack_we    = strobe[ADDR_ACK];

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_we) begin
            ctrl_d.run     = ctrl_bits[CTRL_RUN];
            ctrl_d.special = ctrl_bits[CTRL_SPEC];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign run     = ctrl_q.run;
    assign special = ctrl_q.special;

endmodule

// File: rtl/mpg_timer.sv
module mpg_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         load_we,
    input  logic [W-1:0] load_val,
    input  logic         clear,
    output logic [W-1:0] count
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_we)    cnt_d = load_val;
        else if (clear) cnt_d = '0;
        else if (run)   cnt_d = cnt_q + W'(1);   // modulo 2^W wrap
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

endmodule

// File: rtl/mpg_compare.sv
module mpg_compare #(
    parameter int W        = 16,
    parameter int PERIOD   = 20000,
    parameter int PW_MIN   = 600,
    parameter int PW_MAX   = 2400,
    parameter int PW_RESET = 1500
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         special,
    input  logic [W-1:0] timer,
    input  logic         ctrl_we,
    input  logic         cmp_lo_we,
    input  logic         cmp_hi_we,
    input  logic         width_we,
    input  logic [W-1:0] wr_data,
    output logic         match,
    output logic         level,
    output logic [W-1:0] cmp,
    output logic [W-1:0] width_act
);

    import mpg_pkg::CTRL_LEVEL;

    localparam int           HALF     = W / 2;
    localparam logic [W-1:0] PERIOD_V = W'(PERIOD);
    localparam logic [W-1:0] MIN_V    = W'(PW_MIN);
    localparam logic [W-1:0] MAX_V    = W'(PW_MAX);
    localparam logic [W-1:0] RESET_V  = W'(PW_RESET);

    typedef struct packed {
        logic [W-1:0] cmp;
        logic         level;
        logic [W-1:0] width_pend;
        logic [W-1:0] width_act;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       advance;

    function automatic logic [W-1:0] clamp_width(input logic [W-1:0] v);
        if (v < MIN_V)      return MIN_V;
        else if (v > MAX_V) return MAX_V;
        return v;
    endfunction

    always_comb begin
        st_d    = st_q;
        match   = run && (timer == st_q.cmp);
        advance = match && !special;

        // Compare and level move together in one edge, so the new
        // compare value is in place before the new level can act.
        if (advance) begin
            if (st_q.level) begin
                st_d.cmp       = st_q.cmp + st_q.width_pend;
                st_d.width_act = st_q.width_pend;
            end else begin
                st_d.cmp       = st_q.cmp + (PERIOD_V - st_q.width_act);
            end
            st_d.level = !st_q.level;
        end

        if (width_we)  st_d.width_pend          = clamp_width(wr_data);
        if (ctrl_we)   st_d.level               = wr_data[CTRL_LEVEL];
        if (cmp_lo_we) st_d.cmp[HALF-1:0]       = wr_data[HALF-1:0];
        if (cmp_hi_we) st_d.cmp[W-1:HALF]       = wr_data[HALF-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cmp        <= '0;
            st_q.level      <= 1'b0;
            st_q.width_pend <= RESET_V;
            st_q.width_act  <= RESET_V;
        end else begin
            st_q <= st_d;
        end
    end

    assign level     = st_q.level;
    assign cmp       = st_q.cmp;
    assign width_act = st_q.width_act;

endmodule

// File: rtl/mpg_output.sv
module mpg_output
    import mpg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic special,
    input  logic level,
    input  logic ack_we,
    output logic pin,
    output logic flag
);

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (match && !special) out_d.pin = level;
        if (ack_we)            out_d.flag = 1'b0;
        if (match)             out_d.flag = 1'b1;   // set wins over ack
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pin  = out_q.pin;
    assign flag = out_q.flag;

endmodule

// File: rtl/match_pulse_gen.sv
module match_pulse_gen #(
    parameter int W        = 16,
    parameter int PERIOD   = 20000,
    parameter int PW_MIN   = 600,
    parameter int PW_MAX   = 2400,
    parameter int PW_RESET = 1500
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [2:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    output logic         pin_o,
    output logic         flag_o
);

    logic         run, special;
    logic         ctrl_we, cmp_lo_we, cmp_hi_we, width_we, timer_we, ack_we;
    logic         match, level;
    logic [W-1:0] timer, cmp, width_act;

    mpg_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .ctrl_bits (wr_data[1:0]),
        .run       (run),
        .special   (special),
        .ctrl_we   (ctrl_we),
        .cmp_lo_we (cmp_lo_we),
        .cmp_hi_we (cmp_hi_we),
        .width_we  (width_we),
        .timer_we  (timer_we),
        .ack_we    (ack_we)
    );

    mpg_timer #(.W(W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .load_we  (timer_we),
        .load_val (wr_data),
        .clear    (match && special),
        .count    (timer)
    );

    mpg_compare #(
        .W(W), .PERIOD(PERIOD), .PW_MIN(PW_MIN),
        .PW_MAX(PW_MAX), .PW_RESET(PW_RESET)
    ) i_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .special   (special),
        .timer     (timer),
        .ctrl_we   (ctrl_we),
        .cmp_lo_we (cmp_lo_we),
        .cmp_hi_we (cmp_hi_we),
        .width_we  (width_we),
        .wr_data   (wr_data),
        .match     (match),
        .level     (level),
        .cmp       (cmp),
        .width_act (width_act)
    );

    mpg_output i_output (
        .clk     (clk),
        .rst_n   (rst_n),
        .match   (match),
        .special (special),
        .level   (level),
        .ack_we  (ack_we),
        .pin     (pin_o),
        .flag    (flag_o)
    );

endmodule

// File: rtl/mpg_checker.sv
module mpg_checker #(
    parameter int W      = 16,
    parameter int PW_MIN = 600,
    parameter int PW_MAX = 2400
) (
    input logic         clk,
    input logic         rst_n,
    input logic         run,
    input logic         special,
    input logic         match,
    input logic         level,
    input logic         pin,
    input logic         flag,
    input logic [W-1:0] timer,
    input logic [W-1:0] cmp,
    input logic [W-1:0] width_act,
    input logic         ctrl_we,
    input logic         cmp_lo_we,
    input logic         cmp_hi_we,
    input logic         timer_we,
    input logic         ack_we
);

    assert_timer_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run && !timer_we && !(match && special) |=> timer == $past(timer) + W'(1));

    assert_timer_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !timer_we |=> $stable(timer));

    assert_pin_takes_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match && !special |=> pin == $past(level));

    assert_pin_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !match |=> $stable(pin));

    assert_level_flips_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match && !special && !ctrl_we |=> level != $past(level));

    assert_cmp_advances_R4: assert property (@(posedge clk) disable iff (!rst_n)
        match && !special && !cmp_lo_we && !cmp_hi_we |=> cmp != $past(cmp));

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> flag);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !ack_we |=> flag);

    assert_timer_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match && special && !timer_we |=> timer == '0);

    assert_pin_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match && special |=> $stable(pin));

    assert_cmp_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        match && special && !cmp_lo_we && !cmp_hi_we |=> $stable(cmp));

    assert_width_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        width_act >= W'(PW_MIN) && width_act <= W'(PW_MAX));

endmodule

bind match_pulse_gen mpg_checker #(.W(W), .PW_MIN(PW_MIN), .PW_MAX(PW_MAX)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .special   (special),
    .match     (match),
    .level     (level),
    .pin       (pin_o),
    .flag      (flag_o),
    .timer     (timer),
    .cmp       (cmp),
    .width_act (width_act),
    .ctrl_we   (ctrl_we),
    .cmp_lo_we (cmp_lo_we),
    .cmp_hi_we (cmp_hi_we),
    .timer_we  (timer_we),
    .ack_we    (ack_we)
);

// File: tb/test_match_pulse_gen.sv
module test_match_pulse_gen;

    localparam int PERIOD = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic        pin_o, flag_o;

    always #2.5 clk = ~clk;   // 200 MHz

    match_pulse_gen i_match_pulse_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pin_o(pin_o), .flag_o(flag_o)
    );

    int total = 0, bad = 0;
    bit done = 0, bus_lock = 0, acc_on = 0, clr_on = 0;
    int exp_q[$];
    int cyc = 0, last_rise = -1, rise_cnt = 0, fall_cnt = 0;
    logic pin_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        while (bus_lock) @(negedge clk);
        bus_lock = 1; wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0; bus_lock = 0;
    endtask

    // Driver side of the scoreboard: expected high times
    task automatic push_width(input int w);
        exp_q.push_back(w);
    endtask

    // Monitor: measures edges of the pin in accumulate mode
    always @(negedge clk) begin
        cyc++;
        if (acc_on && pin_o !== pin_prev) begin
            chk(flag_o === 1'b1, "R5 flag at pin edge", int'(flag_o), 1);
            if (pin_o) begin
                if (last_rise >= 0)
                    chk(cyc - last_rise == PERIOD, "R4 period", cyc - last_rise, PERIOD);
                last_rise = cyc;
                rise_cnt++;
            end else begin
                fall_cnt++;
                if (exp_q.size() == 0) begin
                    chk(0, "R4 unexpected pulse", cyc - last_rise, 0);
                end else begin
                    int w;
                    w = exp_q.pop_front();
                    chk(cyc - last_rise == w, "R4/R7/R8 high time", cyc - last_rise, w);
                end
            end
        end
        pin_prev = pin_o;
    end

    // Late flag service with random delay
    initial begin
        forever begin
            @(negedge clk);
            if (clr_on && flag_o) begin
                repeat ($urandom_range(1, 40)) @(negedge clk);
                wr(3'd5, 16'h0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            chk(0, "watchdog", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int t;
        rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
        repeat (4) @(negedge clk);
        chk(pin_o === 1'b0, "R1 pin in reset", int'(pin_o), 0);
        chk(flag_o === 1'b0, "R1 flag in reset", int'(flag_o), 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk(pin_o === 1'b0 && flag_o === 1'b0, "R1 after reset", int'({pin_o, flag_o}), 0);

        // Accumulate mode, compare 0x0104 written as two bytes
        wr(3'd1, 16'h0004);
        wr(3'd2, 16'h0001);
        wr(3'd4, 16'h0000);
        push_width(1500);          // R1 reset width
        push_width(1500);
        acc_on = 1; clr_on = 1;
        wr(3'd0, 16'h0005);        // run, next level high
        repeat (260) @(negedge clk);
        chk(pin_o === 1'b0, "R3 pin before match", int'(pin_o), 0);
        @(negedge clk);
        chk(pin_o === 1'b1, "R3 pin after match", int'(pin_o), 1);

        wait (rise_cnt >= 2);
        repeat (100) @(negedge clk);
        wr(3'd3, 16'd2400);        // R8: applies from next pulse
        push_width(2400);
        wait (rise_cnt >= 3);
        repeat (100) @(negedge clk);
        wr(3'd3, 16'd100);         // R7 clamp up
        push_width(600);
        wait (rise_cnt >= 4);
        repeat (100) @(negedge clk);
        wr(3'd3, 16'd5000);        // R7 clamp down
        push_width(2400);
        wait (fall_cnt >= 5);
        @(negedge clk);
        acc_on = 0; clr_on = 0;
        wr(3'd0, 16'h0000);
        chk(exp_q.size() == 0, "R4 all pulses seen", exp_q.size(), 0);

        // Acknowledge and hold while stopped
        wr(3'd5, 16'h0);
        chk(flag_o === 1'b0, "R5 flag acknowledged", int'(flag_o), 0);
        repeat (50) @(negedge clk);
        chk(flag_o === 1'b0 && pin_o === 1'b0, "R2 stopped timer no match",
            int'({pin_o, flag_o}), 0);

        // Special-event mode, compare 20, level bit set but must not act
        wr(3'd4, 16'h0000);
        wr(3'd1, 16'd20);
        wr(3'd2, 16'h0000);
        wr(3'd0, 16'h0007);
        while (!flag_o) @(negedge clk);
        chk(pin_o === 1'b0, "R6 pin untouched", int'(pin_o), 0);
        t = 0;
        wr(3'd5, 16'h0);
        t += 2;
        chk(flag_o === 1'b0, "R5 cleared between matches", int'(flag_o), 0);
        while (!flag_o) begin
            @(negedge clk);
            t++;
        end
        chk(t == 21, "R6 match interval", t, 21);
        chk(pin_o === 1'b0, "R6 pin still untouched", int'(pin_o), 0);

        wr(3'd0, 16'h0002);        // stop, flag left set
        repeat (60) @(negedge clk);
        chk(flag_o === 1'b1, "R5 flag sticky", int'(flag_o), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule